// File: doc/BRIEF.md
# Accumulator Fetch-Execute Processor

An 8-bit single-accumulator processor that keeps its program and its data in one shared 16-byte memory, reached through a single address/data bus. A control sequencer moves each instruction through explicit register stages: the program counter is copied into an address register, the addressed byte is captured in a data register while the program counter advances, and that byte is then parked in an instruction register so the data register is free for operand traffic. Because the bus is shared, an instruction fetch and an operand access never overlap.

Each instruction byte packs a 4-bit operation in its upper nibble and a 4-bit direct address in its lower nibble. The processor executes loads, stores, wrapping add and subtract, bitwise AND/OR/NOT, single-bit logical shifts, a compare that only updates a zero flag, an unconditional jump and a jump-if-not-equal, and a halt that freezes the machine until reset. The memory itself lives outside the block; it returns read data combinationally for the address driven and commits a write at the clock edge where the write strobe is high.

The sequencer states are FETCH_ADDR (PC to MAR), FETCH_READ (memory to MDR, PC plus one), FETCH_LATCH (MDR to CIR), DECODE (dispatch; jumps and no-ops finish here), OPND_READ (operand memory to MDR), EXECUTE (ALU result to accumulator or flag), STORE_STAGE (accumulator to MDR), STORE_WRITE (write strobe) and HALT. Transitions: FETCH_ADDR→FETCH_READ→FETCH_LATCH→DECODE; DECODE→OPND_READ for memory-operand operations, →STORE_STAGE for store, →EXECUTE for accumulator-only operations, →HALT for halt, →FETCH_ADDR for jumps and no-ops; OPND_READ→EXECUTE; EXECUTE→FETCH_ADDR; STORE_STAGE→STORE_WRITE→FETCH_ADDR; HALT→HALT.

Top module: `accum_fx_cpu`

## Requirements
- R1: A synchronous reset forces the program counter, accumulator and zero flag to 0, clears the halted output, keeps the write strobe low and restarts at FETCH_ADDR.
- R2: Every instruction is fetched in three cycles (PC to MAR, memory read with PC incremented by one, MDR to CIR) and decoded in a fourth; the memory address port always shows the MAR.
- R3: An instruction byte carries the operation in bits 7:4 and a direct address in bits 3:0; operation codes are 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 AND, 6 OR, 7 NOT, 8 shift left, 9 shift right, A compare, B jump, C jump-if-not-equal.
- R4: Load copies the addressed byte into the accumulator; add and subtract combine it with the accumulator modulo 256.
- R5: AND and OR combine the addressed byte bitwise with the accumulator; NOT inverts every accumulator bit.
- R6: Shift left and shift right move the accumulator by one bit and fill the vacated bit with 0.
- R7: Store drives the operand address and the accumulator value on the bus with the write strobe high for exactly one cycle; no other operation writes memory.
- R8: Compare sets the zero flag when accumulator minus the addressed byte is 0 modulo 256 and clears it otherwise, leaving the accumulator unchanged; no other operation alters the flag.
- R9: Jump always loads the program counter from the address field; jump-if-not-equal does so only while the zero flag is 0 and otherwise falls through to the next byte.
- R10: Codes D, E and F change nothing but the program counter increment of the fetch.
- R11: After a halt the halted output stays 1, and the program counter and accumulator hold their values with no memory write until reset.
- R12: Memory-operand operations and store take 6 cycles, NOT and the shifts take 5, and jumps, no-ops and halt take 4, counted from FETCH_ADDR to the next FETCH_ADDR (or to HALT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 4 | Shared memory address, driven from the MAR |
| mem_wdata | output | 8 | Write data, driven from the MDR |
| mem_rdata | input | 8 | Read data for the current address, combinational from memory |
| mem_we | output | 1 | Write strobe, commits mem_wdata at mem_addr on the next edge |
| dbg_pc | output | 4 | Current program counter |
| dbg_acc | output | 8 | Current accumulator |
| halted | output | 1 | High while the sequencer sits in HALT |

## Verification
On every cycle the assertions check the reset values, that a write strobe lasts a single cycle and carries the accumulator, and that a halted machine never writes and never moves its program counter or accumulator. The arithmetic results, wrap-around, zero-filled shifts, compare-flag effect on the conditional jump, skipped stores behind taken jumps, no-op codes and the per-instruction cycle counts only show up through the bench programs, whose stores are matched in order against expected address/data pairs and whose run length to halt is compared with the sum of the per-instruction costs.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADD   = 4'h3,
        OP_SUB   = 4'h4,
        OP_AND   = 4'h5,
        OP_OR    = 4'h6,
        OP_NOT   = 4'h7,
        OP_SHL   = 4'h8,
        OP_SHR   = 4'h9,
        OP_CMP   = 4'hA,
        OP_JMP   = 4'hB,
        OP_JNE   = 4'hC,
        OP_RSV_D = 4'hD,
        OP_RSV_E = 4'hE,
        OP_RSV_F = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        S_FETCH_ADDR  = 4'd0,
        S_FETCH_READ  = 4'd1,
        S_FETCH_LATCH = 4'd2,
        S_DECODE      = 4'd3,
        S_OPND_READ   = 4'd4,
        S_EXECUTE     = 4'd5,
        S_STORE_STAGE = 4'd6,
        S_STORE_WRITE = 4'd7,
        S_HALT        = 4'd8
    } state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_opnd;
        logic pc_inc;
        logic pc_load;
        logic mdr_from_mem;
        logic mdr_from_acc;
        logic cir_load;
        logic acc_load;
        logic flag_load;
        logic mem_we;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e             op,
    input  logic [DATA_W-1:0]   acc,
    input  logic [DATA_W-1:0]   opnd,
    output logic [DATA_W-1:0]   result,
    output logic                zero
);

    logic [DATA_W-1:0] diff;

    always_comb begin
        diff = acc - opnd;
        zero = (diff == '0);
        case (op)
            OP_LOAD: result = opnd;
            OP_ADD:  result = acc + opnd;
            OP_SUB:  result = diff;
            OP_AND:  result = acc & opnd;
            OP_OR:   result = acc | opnd;
            OP_NOT:  result = ~acc;
            OP_SHL:  result = {acc[DATA_W-2:0], 1'b0};
            OP_SHR:  result = {1'b0, acc[DATA_W-1:1]};
            default: result = acc;
        endcase
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e op,
    input  logic    zflag,
    output ctl_t    ctl,
    output logic    halted
);

    state_e state_q;
    state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_FETCH_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control strobes
    always_comb begin
        ctl     = '0;
        state_d = state_q;
        unique case (state_q)
            S_FETCH_ADDR: begin
                ctl.mar_from_pc = 1'b1;
                state_d         = S_FETCH_READ;
            end
            S_FETCH_READ: begin
                ctl.mdr_from_mem = 1'b1;
                ctl.pc_inc       = 1'b1;
                state_d          = S_FETCH_LATCH;
            end
            S_FETCH_LATCH: begin
                ctl.cir_load = 1'b1;
                state_d      = S_DECODE;
            end
            S_DECODE: begin
                case (op)
                    OP_HALT: state_d = S_HALT;
                    OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_CMP: begin
                        ctl.mar_from_opnd = 1'b1;
                        state_d           = S_OPND_READ;
                    end
                    OP_STORE: begin
                        ctl.mar_from_opnd = 1'b1;
                        state_d           = S_STORE_STAGE;
                    end
                    OP_NOT, OP_SHL, OP_SHR: state_d = S_EXECUTE;
                    OP_JMP: begin
                        ctl.pc_load = 1'b1;
                        state_d     = S_FETCH_ADDR;
                    end
                    OP_JNE: begin
                        ctl.pc_load = ~zflag;
                        state_d     = S_FETCH_ADDR;
                    end
                    default: state_d = S_FETCH_ADDR;
                endcase
            end
            S_OPND_READ: begin
                ctl.mdr_from_mem = 1'b1;
                state_d          = S_EXECUTE;
            end
            S_EXECUTE: begin
                if (op == OP_CMP) begin
                    ctl.flag_load = 1'b1;
                end else begin
                    ctl.acc_load = 1'b1;
                end
                state_d = S_FETCH_ADDR;
            end
            S_STORE_STAGE: begin
                ctl.mdr_from_acc = 1'b1;
                state_d          = S_STORE_WRITE;
            end
            S_STORE_WRITE: begin
                ctl.mem_we = 1'b1;
                state_d    = S_FETCH_ADDR;
            end
            S_HALT: state_d = S_HALT;
            default: state_d = S_FETCH_ADDR;
        endcase
    end

    assign halted = (state_q == S_HALT);

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_zero,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mdr,
    output opcode_e           op,
    output logic [DATA_W-1:0] acc,
    output logic              zflag
);

    localparam int OP_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] cir_q;
    logic [ADDR_W-1:0] opnd_addr;

    assign opnd_addr = cir_q[ADDR_W-1:0];
    assign op        = opcode_e'(cir_q[DATA_W-1 -: OP_W]);

    // Program counter
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (ctl.pc_load) begin
            pc <= opnd_addr;
        end else if (ctl.pc_inc) begin
            pc <= pc + 1'b1;
        end
    end

    // Memory address register
    always_ff @(posedge clk) begin
        if (rst) begin
            mar <= '0;
        end else if (ctl.mar_from_pc) begin
            mar <= pc;
        end else if (ctl.mar_from_opnd) begin
            mar <= opnd_addr;
        end
    end

    // Memory data register
    always_ff @(posedge clk) begin
        if (rst) begin
            mdr <= '0;
        end else if (ctl.mdr_from_mem) begin
            mdr <= mem_rdata;
        end else if (ctl.mdr_from_acc) begin
            mdr <= acc;
        end
    end

    // Current instruction register
    always_ff @(posedge clk) begin
        if (rst) begin
            cir_q <= '0;
        end else if (ctl.cir_load) begin
            cir_q <= mdr;
        end
    end

    // Accumulator and zero flag
    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            zflag <= 1'b0;
        end else begin
            if (ctl.acc_load) begin
                acc <= alu_result;
            end
            if (ctl.flag_load) begin
                zflag <= alu_zero;
            end
        end
    end

endmodule

// File: rtl/accum_fx_cpu.sv
module accum_fx_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [DATA_W-1:0] dbg_acc,
    output logic              halted
);

    ctl_t              ctl;
    opcode_e           op;
    logic              zflag;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mdr;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] alu_result;
    logic              alu_zero;

    acc_cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .zflag  (zflag),
        .ctl    (ctl),
        .halted (halted)
    );

    acc_cpu_dpath #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dpath (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .mem_rdata  (mem_rdata),
        .alu_result (alu_result),
        .alu_zero   (alu_zero),
        .pc         (pc),
        .mar        (mar),
        .mdr        (mdr),
        .op         (op),
        .acc        (acc),
        .zflag      (zflag)
    );

    acc_cpu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op     (op),
        .acc    (acc),
        .opnd   (mdr),
        .result (alu_result),
        .zero   (alu_zero)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_we    = ctl.mem_we;
    assign dbg_pc    = pc;
    assign dbg_acc   = acc;

endmodule

// File: rtl/accum_fx_cpu_chk.sv
module accum_fx_cpu_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [ADDR_W-1:0] dbg_pc,
    input logic [DATA_W-1:0] dbg_acc,
    input logic              halted
);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dbg_pc == '0 && dbg_acc == '0 && !halted && !mem_we));

    // R7
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R7
    a_r7_writes_acc: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == dbg_acc));

    // R11
    a_r11_halt_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(dbg_pc) && $stable(dbg_acc)));

    // R11
    a_r11_no_write_halted: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

endmodule

bind accum_fx_cpu accum_fx_cpu_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .dbg_pc    (dbg_pc),
    .dbg_acc   (dbg_acc),
    .halted    (halted)
);

// File: tb/accum_fx_cpu_tb_top.sv
`timescale 1ns/1ps
module accum_fx_cpu_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic       mem_we;
    logic [3:0] dbg_pc;
    logic [7:0] dbg_acc;
    logic       halted;

    logic [7:0]  mem [16];
    logic [11:0] exp_q [$];
    int n_checks = 0;
    int n_fail   = 0;
    int wd       = 0;

    always #2.5 clk = ~clk;

    accum_fx_cpu dut_i (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .dbg_pc    (dbg_pc),
        .dbg_acc   (dbg_acc),
        .halted    (halted)
    );

    // Memory model: combinational read, write at the edge
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Driver side: expected store (address, data)
    task automatic push_store(input logic [3:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    // Monitor: match every write strobe against the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R7 store addr/data", {mem_addr, mem_wdata}, e);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            check(1'b0, "watchdog", wd, 20000);
            finish_up();
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(dbg_pc == 4'h0, "R1 pc at reset", dbg_pc, 0);
        check(dbg_acc == 8'h00, "R1 acc at reset", dbg_acc, 0);
        check(!halted && !mem_we, "R1 halted/we at reset", {halted, mem_we}, 0);
        rst = 1'b0;
    endtask

    // Runs until halted, then checks cycle count, final state and freeze
    task automatic run_prog(input string tag, input int exp_cyc, input logic [3:0] exp_pc,
                            input logic [7:0] exp_acc);
        int cyc = 0;
        logic [3:0] pc_h;
        logic [7:0] acc_h;
        while (!halted && cyc < 1000) begin
            @(posedge clk);
            #1;
            cyc++;
        end
        check(cyc == exp_cyc, {"R12 R2 cycles to halt ", tag}, cyc, exp_cyc);
        check(dbg_pc == exp_pc, {"R9 R11 final pc ", tag}, dbg_pc, exp_pc);
        check(dbg_acc == exp_acc, {"R4 R5 R6 final acc ", tag}, dbg_acc, exp_acc);
        pc_h  = dbg_pc;
        acc_h = dbg_acc;
        repeat (12) @(negedge clk);
        check(halted && dbg_pc == pc_h && dbg_acc == acc_h, {"R11 frozen after halt ", tag},
              {halted, dbg_pc, dbg_acc}, {1'b1, pc_h, acc_h});
        check(exp_q.size() == 0, {"R7 pending stores ", tag}, exp_q.size(), 0);
    endtask

    initial begin
        // Program A: load, wrapping add/sub, and, or, not, stores (R3 R4 R5 R7)
        clear_mem();
        mem[0] = 8'h1E; mem[1] = 8'h3F; mem[2] = 8'h2D; mem[3] = 8'h4E;
        mem[4] = 8'h2C; mem[5] = 8'h5B; mem[6] = 8'h6A; mem[7] = 8'h2C;
        mem[8] = 8'h70; mem[9] = 8'h00;
        mem[10] = 8'h81; mem[11] = 8'h3C; mem[14] = 8'h35; mem[15] = 8'hF0;
        push_store(4'hD, 8'h25);   // R4 add wraps 0x35+0xF0
        push_store(4'hC, 8'hF0);   // R4 sub wraps 0x25-0x35
        push_store(4'hC, 8'hB1);   // R5 and/or
        do_reset();
        run_prog("A", 57, 4'hA, 8'h4E);  // R5 NOT of 0xB1
        check(mem[13] == 8'h25 && mem[12] == 8'hB1, "R7 memory image A",
              {mem[13], mem[12]}, 16'h25B1);

        // Program B: countdown loop with compare and jump-if-not-equal (R8 R9)
        clear_mem();
        mem[0] = 8'h1F; mem[1] = 8'h4E; mem[2] = 8'h2D; mem[3] = 8'hAC;
        mem[4] = 8'hC1; mem[5] = 8'h00;
        mem[12] = 8'h00; mem[14] = 8'h01; mem[15] = 8'h03;
        push_store(4'hD, 8'h02);
        push_store(4'hD, 8'h01);
        push_store(4'hD, 8'h00);
        do_reset();
        run_prog("B", 76, 4'h6, 8'h00);

        // Program C: shifts, compare leaves acc, jump, no-op codes, skipped stores (R6 R8 R9 R10)
        clear_mem();
        mem[0] = 8'h1E; mem[1] = 8'h90; mem[2] = 8'hAF; mem[3] = 8'h2F;
        mem[4] = 8'h80; mem[5] = 8'h80; mem[6] = 8'h2F; mem[7] = 8'hB9;
        mem[8] = 8'h2F; mem[9] = 8'hE0; mem[10] = 8'hCC; mem[11] = 8'h2F;
        mem[12] = 8'h70; mem[13] = 8'h00;
        mem[14] = 8'h96; mem[15] = 8'h11;
        push_store(4'hF, 8'h4B);   // R6 shr zero fill, R8 compare kept acc
        push_store(4'hF, 8'h2C);   // R6 shl drops msb, zero fill
        do_reset();
        run_prog("C", 60, 4'hE, 8'hD3);  // R10 code E is a no-op, R9 jumps skip stores

        finish_up();
    end

endmodule